// File: doc/BRIEF.md
# Sa6 Code Pattern Detector

This block watches the Sa6 spare bit taken from the received service words of a framed 2.048 Mbit/s line. It collects the bits in groups of four and classifies each group. A group is either one of five fixed codes (1000, 1010, 1100, 1110, 1111) or the catch-all class X. A class is declared only when the same class arrives in three groups in a row. The declaration sets a bit in a status register, and the host clears that register by reading it. A new declared class that differs from the one held so far raises a one-cycle change interrupt.

Framing logic outside the block supplies the Sa6 bit with a valid strobe. It also supplies a marker for the first Sa6 bit of a sub-multiframe and flags for basic-frame and multiframe alignment. A mode input chooses how groups are formed. In synchronous mode each group is aligned to the sub-multiframe marker, and updates need multiframe alignment. In asynchronous mode the block counts every four valid bits from reset, and multiframe alignment plays no part. Updates are always held off while basic-frame alignment is lost.

Top module: `sa6_code_detector`

## Requirements
- R1: Only cycles with `sa6_valid` high carry a bit. Four valid bits form a group, and the earliest bit of the group is its most significant bit.
- R2: A group of 1000, 1010, 1100, 1110 or 1111 has class 0, 1, 2, 3 or 4. Every other group has class 5 (X). Class k maps to status bit k, and `det_code` shows the class number.
- R3: A class is declared only on the third consecutive group of that class. A group of a different class restarts the run at one.
- R4: Every group that completes a run of three or more while updates are enabled sets the status bit of its class. Status bits stay set until a read.
- R5: A cycle with `status_rd` high clears the whole status register at the next edge. A bit being set in that same cycle is still set.
- R6: A declaration whose class differs from `det_code` loads `det_code` and pulses `change_irq` for exactly one cycle. A declaration of the class already held raises no pulse.
- R7: While `bf_sync` is low, status, `det_code` and `change_irq` do not update.
- R8: With `sync_mode`=1, a valid bit with `smf_start` high starts a new group. Updates then happen only while `mf_sync` is high.
- R9: With `sync_mode`=0, groups are every four valid bits counted from reset. Both `smf_start` and `mf_sync` are ignored.
- R10: Reset is synchronous and active high. It leaves status at 0, `change_irq` low and `det_code` at 7 (nothing declared).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sa6_bit | input | 1 | Received Sa6 bit |
| sa6_valid | input | 1 | Qualifies `sa6_bit` for this cycle |
| smf_start | input | 1 | Current Sa6 bit is the first of a sub-multiframe |
| bf_sync | input | 1 | Basic-frame alignment held |
| mf_sync | input | 1 | Multiframe alignment held |
| sync_mode | input | 1 | 1: groups follow sub-multiframe; 0: free-running groups |
| status_rd | input | 1 | Host read of the status register (clears it) |
| status | output | 6 | Sticky per-class detection bits |
| det_code | output | 3 | Currently declared class, 7 when none |
| change_irq | output | 1 | One-cycle pulse on a change of declared class |

## Verification
The hardest case to reach is a run that keeps going through a gated interval. In that case the repeat count must carry on while updates are blocked. The first group after the gate lifts must then declare the class at once, with no fresh run of three. The stimulus sends three groups with `bf_sync` low, or with `mf_sync` low in synchronous mode, and then one more group of the same class with the gate open. It expects the declaration and the interrupt right on that fourth group. Group alignment is tested by sending two loose bits before the groups. In synchronous mode the sub-multiframe marker must realign the grouping. In asynchronous mode the marker must be ignored, so the same stream is expected to read as class X.

// File: rtl/sa6_det_pkg.sv
package sa6_det_pkg;

    localparam int SA6_GROUP_LEN = 4;
    localparam int SA6_REPEAT_N  = 3;
    localparam int SA6_NUM_CLASS = 6;

    typedef enum logic [2:0] {
        CLS_1000 = 3'd0,
        CLS_1010 = 3'd1,
        CLS_1100 = 3'd2,
        CLS_1110 = 3'd3,
        CLS_1111 = 3'd4,
        CLS_X    = 3'd5,
        CLS_NONE = 3'd7
    } sa6_cls_e;

    typedef struct packed {
        logic                     done;
        logic [SA6_GROUP_LEN-1:0] bits;
    } sa6_group_t;

    typedef struct packed {
        logic     confirm;
        sa6_cls_e cls;
    } sa6_verdict_t;

    // Earliest received bit is the MSB of the argument.
    function automatic sa6_cls_e sa6_classify(input logic [SA6_GROUP_LEN-1:0] g);
        case (g)
            4'b1000: return CLS_1000;
            4'b1010: return CLS_1010;
            4'b1100: return CLS_1100;
            4'b1110: return CLS_1110;
            4'b1111: return CLS_1111;
            default: return CLS_X;
        endcase
    endfunction

endpackage

// File: rtl/sa6_grouper.sv
module sa6_grouper
    import sa6_det_pkg::*;
#(
    parameter int G = SA6_GROUP_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_i,
    input  logic       valid_i,
    input  logic       smf_i,
    input  logic       align_sub_i,
    output sa6_group_t grp_o
);
    localparam int CW = (G > 1) ? $clog2(G) : 1;
    localparam logic [CW-1:0] LAST = CW'(G - 1);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] pos_eff;
    logic [G-2:0]  shreg_q;

    // Sub-multiframe marker realigns the group in synchronous mode only.
    always_comb begin
        pos_eff = (align_sub_i && smf_i) ? '0 : pos_q;
        grp_o.done = valid_i && (pos_eff == LAST);
        grp_o.bits = {shreg_q, bit_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            shreg_q <= '0;
        end else if (valid_i) begin
            shreg_q <= {shreg_q[G-3:0], bit_i};
            pos_q   <= (pos_eff == LAST) ? '0 : pos_eff + 1'b1;
        end
    end

    p_pos_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST);
    p_idle_holds_pos_r1: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(pos_q));

endmodule

// File: rtl/sa6_validator.sv
module sa6_validator
    import sa6_det_pkg::*;
#(
    parameter int REP = SA6_REPEAT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  sa6_group_t   grp_i,
    output sa6_verdict_t verdict_o
);
    localparam int CNTW = $clog2(REP + 1);
    localparam logic [CNTW-1:0] REP_C = CNTW'(REP);

    sa6_cls_e        prev_q;
    sa6_cls_e        cls;
    logic [CNTW-1:0] run_q;
    logic [CNTW-1:0] run_nxt;

    always_comb begin
        cls = sa6_classify(grp_i.bits);
        if (cls == prev_q && run_q != '0)
            run_nxt = (run_q == REP_C) ? REP_C : run_q + 1'b1;
        else
            run_nxt = CNTW'(1);
        verdict_o.cls     = cls;
        verdict_o.confirm = grp_i.done && (run_nxt == REP_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= CLS_NONE;
            run_q  <= '0;
        end else if (grp_i.done) begin
            prev_q <= cls;
            run_q  <= run_nxt;
        end
    end

    p_run_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        run_q <= REP_C);
    p_confirm_after_run_r3: assert property (@(posedge clk) disable iff (rst)
        verdict_o.confirm |-> (run_q >= REP_C - 1'b1) && (prev_q == verdict_o.cls));

endmodule

// File: rtl/sa6_status.sv
module sa6_status
    import sa6_det_pkg::*;
#(
    parameter int NC = SA6_NUM_CLASS
) (
    input  logic          clk,
    input  logic          rst,
    input  sa6_verdict_t  verdict_i,
    input  logic          upd_en_i,
    input  logic          rd_i,
    output logic [NC-1:0] status_o,
    output sa6_cls_e      det_o,
    output logic          irq_o
);
    logic          take;
    logic [NC-1:0] set_vec;

    always_comb begin
        take    = verdict_i.confirm && upd_en_i;
        set_vec = take ? (NC'(1) << verdict_i.cls) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            det_o    <= CLS_NONE;
            irq_o    <= 1'b0;
        end else begin
            status_o <= (rd_i ? '0 : status_o) | set_vec;
            if (take && verdict_i.cls != det_o) begin
                det_o <= verdict_i.cls;
                irq_o <= 1'b1;
            end else begin
                irq_o <= 1'b0;
            end
        end
    end

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        rd_i && (set_vec == '0) |=> status_o == '0);
    p_irq_marks_change_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> det_o != $past(det_o));
    p_code_moves_with_irq_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(det_o) |-> irq_o);

endmodule

// File: rtl/sa6_code_detector.sv
module sa6_code_detector
    import sa6_det_pkg::*;
#(
    parameter int GROUP_LEN = SA6_GROUP_LEN,
    parameter int REPEAT_N  = SA6_REPEAT_N,
    parameter int NUM_CLASS = SA6_NUM_CLASS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sa6_bit,
    input  logic                 sa6_valid,
    input  logic                 smf_start,
    input  logic                 bf_sync,
    input  logic                 mf_sync,
    input  logic                 sync_mode,
    input  logic                 status_rd,
    output logic [NUM_CLASS-1:0] status,
    output logic [2:0]           det_code,
    output logic                 change_irq
);
    sa6_group_t   grp;
    sa6_verdict_t verdict;
    sa6_cls_e     det;
    logic         upd_en;

    assign upd_en   = bf_sync && (!sync_mode || mf_sync);
    assign det_code = det;

    sa6_grouper #(.G(GROUP_LEN)) u_grouper (
        .clk         (clk),
        .rst         (rst),
        .bit_i       (sa6_bit),
        .valid_i     (sa6_valid),
        .smf_i       (smf_start),
        .align_sub_i (sync_mode),
        .grp_o       (grp)
    );

    sa6_validator #(.REP(REPEAT_N)) u_validator (
        .clk       (clk),
        .rst       (rst),
        .grp_i     (grp),
        .verdict_o (verdict)
    );

    sa6_status #(.NC(NUM_CLASS)) u_status (
        .clk      (clk),
        .rst      (rst),
        .verdict_i(verdict),
        .upd_en_i (upd_en),
        .rd_i     (status_rd),
        .status_o (status),
        .det_o    (det),
        .irq_o    (change_irq)
    );

    p_bf_gate_r7: assert property (@(posedge clk) disable iff (rst)
        !bf_sync |=> !change_irq && $stable(det_code));
    p_mf_gate_r8: assert property (@(posedge clk) disable iff (rst)
        sync_mode && !mf_sync |=> !change_irq && $stable(det_code));
    p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
        change_irq |=> !change_irq);

endmodule

// File: tb/tb_sa6_code_detector.sv
module tb_sa6_code_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sa6_bit = 1'b0, sa6_valid = 1'b0, smf_start = 1'b0;
    logic       bf_sync = 1'b1, mf_sync = 1'b1, sync_mode = 1'b0, status_rd = 1'b0;
    logic [5:0] status;
    logic [2:0] det_code;
    logic       change_irq;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    sa6_code_detector dut (
        .clk(clk), .rst(rst), .sa6_bit(sa6_bit), .sa6_valid(sa6_valid),
        .smf_start(smf_start), .bf_sync(bf_sync), .mf_sync(mf_sync),
        .sync_mode(sync_mode), .status_rd(status_rd), .status(status),
        .det_code(det_code), .change_irq(change_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cls(input int v);
        case (v)
            8:  return 0;
            10: return 1;
            12: return 2;
            14: return 3;
            15: return 4;
            default: return 5;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One valid bit, then an idle cycle whose data line carries the inverse.
    task automatic send_bit(input logic b, input logic smf, input logic rd);
        @(negedge clk);
        sa6_bit = b; sa6_valid = 1'b1; smf_start = smf; status_rd = rd;
        @(negedge clk);
        sa6_valid = 1'b0; smf_start = 1'b0; status_rd = 1'b0; sa6_bit = ~b;
    endtask

    task automatic send_group(input logic [3:0] c, input logic smf, input logic rd_last);
        for (int i = 3; i >= 0; i--)
            send_bit(c[i], smf && (i == 3), rd_last && (i == 0));
    endtask

    task automatic read_status();
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R10 status", int'(status), 0);
        check("R10 det_code", int'(det_code), 7);
        check("R10 irq", int'(change_irq), 0);

        // Sweep all 16 group values, free-running mode.
        for (int v = 0; v < 16; v++) begin
            do_reset();
            send_group(4'(v), 1'b0, 1'b0);
            send_group(4'(v), 1'b0, 1'b0);
            check("R3 none after two", int'(det_code), 7);
            check("R3 status after two", int'(status), 0);
            send_group(4'(v), 1'b0, 1'b0);
            check("R1 R2 class", int'(det_code), exp_cls(v));
            check("R4 status bit", int'(status), 1 << exp_cls(v));
            check("R6 irq on change", int'(change_irq), 1);
            send_group(4'(v), 1'b0, 1'b0);
            check("R6 no irq same class", int'(change_irq), 0);
            read_status();
            check("R5 cleared by read", int'(status), 0);
        end

        // Run restart on a differing group.
        do_reset();
        send_group(4'b1010, 1'b0, 1'b0);
        send_group(4'b1010, 1'b0, 1'b0);
        send_group(4'b1100, 1'b0, 1'b0);
        send_group(4'b1010, 1'b0, 1'b0);
        send_group(4'b1010, 1'b0, 1'b0);
        check("R3 restart keeps none", int'(det_code), 7);
        send_group(4'b1010, 1'b0, 1'b0);
        check("R3 declared after restart", int'(det_code), 1);

        // Change of class, sticky bits, read with simultaneous set.
        do_reset();
        repeat (3) send_group(4'b1111, 1'b0, 1'b0);
        repeat (3) send_group(4'b1000, 1'b0, 1'b0);
        check("R6 change irq", int'(change_irq), 1);
        check("R6 new code", int'(det_code), 0);
        check("R4 both bits held", int'(status), 6'b010001);
        send_group(4'b1000, 1'b0, 1'b1);
        check("R5 set wins over read", int'(status), 6'b000001);

        // Basic-frame alignment loss blocks updates; run carries on.
        do_reset();
        bf_sync = 1'b0;
        repeat (3) send_group(4'b1100, 1'b0, 1'b0);
        check("R7 code held", int'(det_code), 7);
        check("R7 status held", int'(status), 0);
        check("R7 no irq", int'(change_irq), 0);
        bf_sync = 1'b1;
        send_group(4'b1100, 1'b0, 1'b0);
        check("R7 declares after gate", int'(det_code), 2);
        check("R7 irq after gate", int'(change_irq), 1);

        // Synchronous mode: marker realigns grouping.
        do_reset();
        sync_mode = 1'b1; mf_sync = 1'b1;
        send_bit(1'b1, 1'b0, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        repeat (3) send_group(4'b1010, 1'b1, 1'b0);
        check("R8 aligned declare", int'(det_code), 1);
        read_status();
        mf_sync = 1'b0;
        repeat (3) send_group(4'b1100, 1'b1, 1'b0);
        check("R8 mf loss holds code", int'(det_code), 1);
        check("R8 mf loss holds status", int'(status), 0);
        check("R8 mf loss no irq", int'(change_irq), 0);
        mf_sync = 1'b1;
        send_group(4'b1100, 1'b1, 1'b0);
        check("R8 declares after mf", int'(det_code), 2);

        // Asynchronous mode: marker and mf_sync ignored.
        do_reset();
        sync_mode = 1'b0; mf_sync = 1'b0;
        send_bit(1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b0, 1'b0);
        repeat (4) send_group(4'b1000, 1'b1, 1'b0);
        check("R9 free-running groups", int'(det_code), 5);
        check("R9 status X", int'(status), 6'b100000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule